// File: doc/BRIEF.md
# Three-Phase Gate Interlock Protection Controller

This block sits between a motor controller's six PWM commands and the six gate-enable lines of a three-phase bridge. Each phase has an upper command and a lower command. The block turns on at most one switch per phase, and it passes commands through only when they have been steady for a minimum width. It also forces gates off for four reasons: an overcurrent flag, a main-supply undervoltage flag, a per-phase upper-supply fault, or an external drive enable held low. None of these adds dead time; spacing between upper and lower turn-on is left to the controller.

Overcurrent is the only condition that raises the fault output. That output is an open-drain pull-down request, where 1 means pull the line low. Once the overcurrent flag is gone, the fault is held for a fixed time and then clears by itself. When an upper supply recovers, that phase's upper gate stays blocked until its command shows a new rising edge. All inputs are synchronous digital flags and pass through two-flop synchronizers. The hold time and the minimum pulse width are set in microseconds and nanoseconds and are converted to clock cycles from the clock-frequency parameter.

Top module: `gate_interlock_ctrl`

## Requirements
- R1: In each phase, an asserted upper command with the lower command deasserted drives only that phase's gate_hi bit high. An asserted lower command with the upper command deasserted drives only its gate_lo bit high. gate_hi and gate_lo of one phase are never 1 together. Bit i of every phase vector belongs to phase i.
- R2: In a phase where both commands are equal (both 0 or both 1), both gates of that phase are 0.
- R3: Three clock edges after oc_flag is sampled high, all six gates are 0 and fault_pd is 1, whatever the commands.
- R4: fault_pd stays 1 while oc_flag is high. After oc_flag falls, fault_pd stays 1 for HOLD_CYC more edges, where HOLD_CYC = CLK_HZ/1000 * HOLD_US / 1000 (100 cycles in the bench). It then returns to 0 by itself and the gates follow the commands again.
- R5: While drive_en is 0, all gates are 0 and fault_pd stays 0.
- R6: While main_uv is 1, all gates are 0 and fault_pd stays 0. Three edges after main_uv is sampled low, the gates follow the commands again.
- R7: up_ok[i] = 0 forces gate_hi[i] to 0 only. The lower gate of that phase and all gates of the other phases are not affected.
- R8: After up_ok[i] returns to 1, gate_hi[i] stays 0 even if its upper command is already high. It is released only after that command has been filtered low and then high again.
- R9: A command change that lasts fewer than MIN_CYC cycles never reaches the gates, where MIN_CYC = CLK_HZ/1000 * MIN_PULSE_NS / 1000000 (5 cycles in the bench). This holds for both on pulses and off pulses. A change that lasts MIN_CYC cycles or more is passed.
- R10: In a phase whose commands swap from upper to lower in one step, gate_hi falls and gate_lo rises on the same clock edge, with no added gap.
- R11: While rst is high and on the first edge after it, all gates are 0 and fault_pd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | 3 | Upper switch PWM commands, bit i = phase i |
| lo_cmd | input | 3 | Lower switch PWM commands, bit i = phase i |
| oc_flag | input | 1 | Overcurrent detected |
| main_uv | input | 1 | Main supply undervoltage |
| up_ok | input | 3 | Upper supply good, per phase |
| drive_en | input | 1 | External drive enable, 0 blocks all gates |
| gate_hi | output | 3 | Upper gate enables |
| gate_lo | output | 3 | Lower gate enables |
| fault_pd | output | 1 | Fault pull-down request, 1 = pull fault line low |

## Verification
The bench builds the block with a 50 MHz clock, a 2 µs hold time and a 100 ns minimum pulse width. With these values the fault hold lasts 100 cycles and the filter width is 5 cycles, so a complete latch, hold and release fits in a short run. The bench also drives pulses of exactly 4 and 5 cycles to probe the filter boundary. With production values, hundreds of thousands of cycles per fault would hide these edges.

// File: rtl/gic_pkg.sv
package gic_pkg;

    localparam int GIC_PHASES = 3;

    typedef enum logic [1:0] {
        LEG_OFF   = 2'b00,
        LEG_LOWER = 2'b01,
        LEG_UPPER = 2'b10
    } leg_e;

    typedef struct packed {
        logic [GIC_PHASES-1:0] hi;
        logic [GIC_PHASES-1:0] lo;
    } cmd_t;

    typedef struct packed {
        logic                  oc;
        logic                  main_uv;
        logic                  en;
        logic [GIC_PHASES-1:0] up_ok;
    } flags_t;

    localparam int CMD_W   = $bits(cmd_t);
    localparam int FLAGS_W = $bits(flags_t);

    // Safe synchronizer contents at reset: no fault, drive blocked, supplies good.
    localparam flags_t FLAGS_SAFE = '{oc: 1'b0, main_uv: 1'b0, en: 1'b0, up_ok: '1};

    function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
        int unsigned c;
        c = (hz / 1000) * us / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned hz, input int unsigned ns);
        int unsigned c;
        c = (hz / 1000) * ns / 1000000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic leg_e leg_decode(input logic hi, input logic lo);
        case ({hi, lo})
            2'b10:   return LEG_UPPER;
            2'b01:   return LEG_LOWER;
            default: return LEG_OFF;
        endcase
    endfunction

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gic_pulse_filter.sv
module gic_pulse_filter #(
    parameter int          W       = 6,
    parameter int unsigned MIN_CYC = 50
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    generate
        if (MIN_CYC <= 1) begin : g_bypass
            always_ff @(posedge clk) begin
                if (rst) clean <= '0;
                else     clean <= raw;
            end
        end else begin : g_count
            localparam int CW = $clog2(MIN_CYC);
            for (genvar i = 0; i < W; i++) begin : g_bit
                logic [CW-1:0] run;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        run      <= '0;
                        clean[i] <= 1'b0;
                    end else if (raw[i] == clean[i]) begin
                        run <= '0;
                    end else if (run == CW'(MIN_CYC - 1)) begin
                        clean[i] <= raw[i];
                        run      <= '0;
                    end else begin
                        run <= run + 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gic_fault_latch.sv
module gic_fault_latch #(
    parameter int unsigned HOLD_CYC = 450000
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    output logic latched
);
    localparam int HW = $clog2(HOLD_CYC);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched  <= 1'b0;
            hold_cnt <= '0;
        end else if (oc_s) begin
            latched  <= 1'b1;
            hold_cnt <= '0;
        end else if (latched) begin
            if (hold_cnt == HW'(HOLD_CYC - 1)) begin
                latched  <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gic_phase_leg.sv
module gic_phase_leg
    import gic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hi_f,
    input  logic lo_f,
    input  logic up_ok_s,
    input  logic block_all,
    output logic gate_hi,
    output logic gate_lo
);
    leg_e want;
    logic armed;
    logic hi_prev;
    logic hi_rise;

    assign want    = leg_decode(hi_f, lo_f);
    assign hi_rise = hi_f & ~hi_prev;

    // Upper re-arm: cleared by supply loss, set again only by a fresh command edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b1;
            hi_prev <= 1'b0;
        end else begin
            hi_prev <= hi_f;
            if (!up_ok_s)     armed <= 1'b0;
            else if (hi_rise) armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= !block_all && armed && up_ok_s && (want == LEG_UPPER);
            gate_lo <= !block_all && (want == LEG_LOWER);
        end
    end
endmodule

// File: rtl/gate_interlock_ctrl.sv
module gate_interlock_ctrl
    import gic_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50000000,
    parameter int unsigned HOLD_US      = 9000,
    parameter int unsigned MIN_PULSE_NS = 1000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GIC_PHASES-1:0] hi_cmd,
    input  logic [GIC_PHASES-1:0] lo_cmd,
    input  logic                  oc_flag,
    input  logic                  main_uv,
    input  logic [GIC_PHASES-1:0] up_ok,
    input  logic                  drive_en,
    output logic [GIC_PHASES-1:0] gate_hi,
    output logic [GIC_PHASES-1:0] gate_lo,
    output logic                  fault_pd
);
    localparam int unsigned HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US);
    localparam int unsigned MIN_CYC  = ns_to_cycles(CLK_HZ, MIN_PULSE_NS);

    cmd_t   cmd_raw, cmd_s, cmd_f;
    flags_t flg_raw, flg_s;
    logic   oc_latched;
    logic   block_all;

    assign cmd_raw = '{hi: hi_cmd, lo: lo_cmd};
    assign flg_raw = '{oc: oc_flag, main_uv: main_uv, en: drive_en, up_ok: up_ok};

    gic_sync #(.W(CMD_W), .RST_VAL('0)) u_cmd_sync (
        .clk(clk), .rst(rst), .d(cmd_raw), .q(cmd_s)
    );

    gic_sync #(.W(FLAGS_W), .RST_VAL(FLAGS_SAFE)) u_flag_sync (
        .clk(clk), .rst(rst), .d(flg_raw), .q(flg_s)
    );

    gic_pulse_filter #(.W(CMD_W), .MIN_CYC(MIN_CYC)) u_filter (
        .clk(clk), .rst(rst), .raw(cmd_s), .clean(cmd_f)
    );

    gic_fault_latch #(.HOLD_CYC(HOLD_CYC)) u_fault (
        .clk(clk), .rst(rst), .oc_s(flg_s.oc), .latched(oc_latched)
    );

    assign block_all = flg_s.oc | oc_latched | flg_s.main_uv | ~flg_s.en;
    assign fault_pd  = oc_latched;

    generate
        for (genvar p = 0; p < GIC_PHASES; p++) begin : g_leg
            gic_phase_leg u_leg (
                .clk      (clk),
                .rst      (rst),
                .hi_f     (cmd_f.hi[p]),
                .lo_f     (cmd_f.lo[p]),
                .up_ok_s  (flg_s.up_ok[p]),
                .block_all(block_all),
                .gate_hi  (gate_hi[p]),
                .gate_lo  (gate_lo[p])
            );
        end
    endgenerate
endmodule

// File: rtl/gic_checker.sv
module gic_checker
    import gic_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [GIC_PHASES-1:0] hi_cmd,
    input logic [GIC_PHASES-1:0] lo_cmd,
    input logic                  oc_flag,
    input logic                  main_uv,
    input logic [GIC_PHASES-1:0] up_ok,
    input logic                  drive_en,
    input logic [GIC_PHASES-1:0] gate_hi,
    input logic [GIC_PHASES-1:0] gate_lo,
    input logic                  fault_pd
);
    logic [2:0] age;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end
    assign warm = (age >= 3'd4);

    for (genvar p = 0; p < GIC_PHASES; p++) begin : g_ph
        p_one_side_r1: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[p] && gate_lo[p]));
        p_up_supply_r7: assert property (@(posedge clk) disable iff (rst)
            (warm && !$past(up_ok[p], 3)) |-> !gate_hi[p]);
    end

    p_oc_trip_r3: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(oc_flag, 3)) |-> (fault_pd && gate_hi == '0 && gate_lo == '0));

    p_fault_source_r3: assert property (@(posedge clk) disable iff (rst)
        (warm && $rose(fault_pd)) |-> $past(oc_flag, 3));

    p_fault_release_r4: assert property (@(posedge clk) disable iff (rst)
        (warm && $fell(fault_pd)) |-> !$past(oc_flag, 3));

    p_enable_block_r5: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(drive_en, 3)) |-> (gate_hi == '0 && gate_lo == '0));

    p_main_uv_block_r6: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(main_uv, 3)) |-> (gate_hi == '0 && gate_lo == '0));

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> (gate_hi == '0 && gate_lo == '0 && !fault_pd));
endmodule

bind gate_interlock_ctrl gic_checker chk_i (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .oc_flag(oc_flag),
    .main_uv(main_uv), .up_ok(up_ok), .drive_en(drive_en),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_pd(fault_pd)
);

// File: tb/gate_interlock_ctrl_tb_top.sv
module gate_interlock_ctrl_tb_top;

    localparam int HOLD = 100; // 50 MHz * 2 us
    localparam int MINW = 5;   // 50 MHz * 100 ns

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_cmd = '0, lo_cmd = '0, up_ok = 3'b111;
    logic       oc_flag = 1'b0, main_uv = 1'b0, drive_en = 1'b0;
    logic [2:0] gate_hi, gate_lo;
    logic       fault_pd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gate_interlock_ctrl #(.CLK_HZ(50000000), .HOLD_US(2), .MIN_PULSE_NS(100)) dut_i (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .oc_flag(oc_flag),
        .main_uv(main_uv), .up_ok(up_ok), .drive_en(drive_en),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_pd(fault_pd)
    );

    // ---------------- behavioural reference model ----------------
    bit [2:0] q_hi[$], q_lo[$], q_up[$];
    bit       q_oc[$], q_uv[$], q_en[$];
    bit [2:0] m_hi, m_lo, m_up;
    bit       m_oc, m_uv, m_en;
    bit [2:0] f_hi, f_lo, prev_hi, armed;
    int       run_hi[3], run_lo[3];
    bit       latched;
    int       hold_left;
    bit [2:0] exp_hi, exp_lo;
    bit       exp_f;

    task automatic model_reset();
        q_hi = {3'b000, 3'b000}; q_lo = {3'b000, 3'b000}; q_up = {3'b111, 3'b111};
        q_oc = {1'b0, 1'b0};     q_uv = {1'b0, 1'b0};     q_en = {1'b0, 1'b0};
        f_hi = '0; f_lo = '0; prev_hi = '0; armed = 3'b111;
        for (int i = 0; i < 3; i++) begin run_hi[i] = 0; run_lo[i] = 0; end
        latched = 0; hold_left = 0; exp_hi = '0; exp_lo = '0; exp_f = 0;
    endtask

    task automatic filt_step(inout bit f, inout int run, input bit raw);
        if (raw == f) run = 0;
        else begin
            run++;
            if (run >= MINW) begin f = raw; run = 0; end
        end
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            bit blk;
            m_hi = q_hi[0]; m_lo = q_lo[0]; m_up = q_up[0];
            m_oc = q_oc[0]; m_uv = q_uv[0]; m_en = q_en[0];
            blk = m_oc || latched || m_uv || !m_en;
            for (int p = 0; p < 3; p++) begin
                exp_hi[p] = !blk && armed[p] && m_up[p] && f_hi[p] && !f_lo[p];
                exp_lo[p] = !blk && !f_hi[p] && f_lo[p];
            end
            for (int p = 0; p < 3; p++) begin
                if (!m_up[p]) armed[p] = 0;
                else if (f_hi[p] && !prev_hi[p]) armed[p] = 1;
            end
            prev_hi = f_hi;
            for (int p = 0; p < 3; p++) begin
                bit th, tl;
                th = f_hi[p]; tl = f_lo[p];
                filt_step(th, run_hi[p], m_hi[p]);
                filt_step(tl, run_lo[p], m_lo[p]);
                f_hi[p] = th; f_lo[p] = tl;
            end
            if (m_oc) begin latched = 1; hold_left = HOLD; end
            else if (latched) begin
                hold_left--;
                if (hold_left == 0) latched = 0;
            end
            exp_f = latched;
            void'(q_hi.pop_front()); void'(q_lo.pop_front()); void'(q_up.pop_front());
            void'(q_oc.pop_front()); void'(q_uv.pop_front()); void'(q_en.pop_front());
            q_hi.push_back(hi_cmd); q_lo.push_back(lo_cmd); q_up.push_back(up_ok);
            q_oc.push_back(oc_flag); q_uv.push_back(main_uv); q_en.push_back(drive_en);
        end
    end

    bit [2:0] seen_hi_on, seen_hi_off;

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (gate_hi !== exp_hi || gate_lo !== exp_lo || fault_pd !== exp_f) begin
                errors++;
                $display("FAIL R1/R3/R4 model t=%0t: hi=%b lo=%b f=%b expected hi=%b lo=%b f=%b",
                         $time, gate_hi, gate_lo, fault_pd, exp_hi, exp_lo, exp_f);
            end
            seen_hi_on  |= gate_hi;
            seen_hi_off |= ~gate_hi;
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] h, input logic [2:0] l);
        @(negedge clk); #1; hi_cmd = h; lo_cmd = l;
    endtask

    task automatic settle();
        repeat (MINW + 6) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        chk("R11 reset outputs", {gate_hi, gate_lo, fault_pd}, 7'b0);
        #1; rst = 0; drive_en = 1;
        @(negedge clk);
        chk("R11 first edge after reset", {gate_hi, gate_lo, fault_pd}, 7'b0);

        // R1: single-sided commands
        drive(3'b101, 3'b010); settle();
        chk("R1 single side", {gate_hi, gate_lo, fault_pd}, {3'b101, 3'b010, 1'b0});

        // R2: equal commands
        drive(3'b011, 3'b010); settle();
        chk("R2 equal commands", {gate_hi, gate_lo, fault_pd}, {3'b001, 3'b000, 1'b0});

        // R10: swap upper to lower in one step on phase 2
        drive(3'b100, 3'b000); settle();
        begin
            bit ok = 0;
            logic [2:0] ph, pl;
            drive(3'b000, 3'b100);
            ph = gate_hi; pl = gate_lo;
            for (int k = 0; k < MINW + 8; k++) begin
                @(negedge clk);
                if (gate_lo[2] && !pl[2]) ok = ph[2] && !gate_hi[2];
                ph = gate_hi; pl = gate_lo;
            end
            chk("R10 no gap on swap", {6'b0, ok}, 7'b1);
        end

        // R9: short on-pulse rejected, exact width passed
        drive(3'b000, 3'b000); settle();
        seen_hi_on = '0;
        drive(3'b001, 3'b000); repeat (MINW - 1) @(negedge clk); #1; hi_cmd = 3'b000;
        settle();
        chk("R9 short on-pulse rejected", {4'b0, seen_hi_on}, 7'b0);
        seen_hi_on = '0;
        drive(3'b001, 3'b000); repeat (MINW) @(negedge clk); #1; hi_cmd = 3'b000;
        settle();
        chk("R9 min-width on-pulse passed", {4'b0, seen_hi_on}, 7'b0000001);
        // short off-pulse
        drive(3'b001, 3'b000); settle();
        seen_hi_off = '0;
        drive(3'b000, 3'b000); repeat (MINW - 1) @(negedge clk); #1; hi_cmd = 3'b001;
        settle();
        chk("R9 short off-pulse rejected", {6'b0, seen_hi_off[0]}, 7'b0);

        // R3/R4: overcurrent trip and timed release
        drive(3'b101, 3'b010); settle();
        @(negedge clk); #1; oc_flag = 1;
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R3 trip", {gate_hi, gate_lo, fault_pd}, {6'b0, 1'b1});
        drive(3'b010, 3'b101);
        repeat (10) @(negedge clk);
        chk("R3 commands overridden", {gate_hi, gate_lo, fault_pd}, {6'b0, 1'b1});
        drive(3'b101, 3'b010);
        @(negedge clk); #1; oc_flag = 0;
        repeat (HOLD + 1) @(posedge clk); @(negedge clk);
        chk("R4 still held", {6'b0, fault_pd}, 7'b1);
        @(posedge clk); @(negedge clk);
        chk("R4 self clear", {6'b0, fault_pd}, 7'b0);
        repeat (3) @(negedge clk);
        chk("R4 resume", {gate_hi, gate_lo, fault_pd}, {3'b101, 3'b010, 1'b0});

        // R5: external enable low
        @(negedge clk); #1; drive_en = 0;
        settle();
        chk("R5 enable low", {gate_hi, gate_lo, fault_pd}, 7'b0);
        @(negedge clk); #1; drive_en = 1;
        settle();
        chk("R5 enable restored", {gate_hi, gate_lo, fault_pd}, {3'b101, 3'b010, 1'b0});

        // R6: main undervoltage, immediate resume
        @(negedge clk); #1; main_uv = 1;
        settle();
        chk("R6 main uv off", {gate_hi, gate_lo, fault_pd}, 7'b0);
        @(negedge clk); #1; main_uv = 0;
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R6 immediate resume", {gate_hi, gate_lo, fault_pd}, {3'b101, 3'b010, 1'b0});

        // R7: upper supply loss on phase 0
        drive(3'b011, 3'b100); settle();
        @(negedge clk); #1; up_ok = 3'b110;
        settle();
        chk("R7 only upper 0 off", {gate_hi, gate_lo, fault_pd}, {3'b010, 3'b100, 1'b0});

        // R8: re-arm needs fresh rising edge
        @(negedge clk); #1; up_ok = 3'b111;
        settle();
        chk("R8 stays off with held command", {gate_hi, gate_lo, fault_pd}, {3'b010, 3'b100, 1'b0});
        drive(3'b010, 3'b100); settle();
        drive(3'b011, 3'b100); settle();
        chk("R8 released by new edge", {gate_hi, gate_lo, fault_pd}, {3'b011, 3'b100, 1'b0});

        finish_run();
    end
endmodule